// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one 8-bit parallel port channel that moves bytes between a CPU and a peripheral. A strobe/acknowledge handshake paces each transfer, and both directions hold their data in latches. The channel runs in one of three modes:

- **Input:** the peripheral strobes a byte into an input latch.
- **Output:** the CPU writes a byte that waits in an output latch until the peripheral acknowledges it.
- **Bidirectional:** both paths are active, and the channel drives its pins only while the peripheral holds acknowledge low.

Two buffer-full flags follow the handshake and are visible on the peripheral side. An interrupt line asks the CPU for service when input data is waiting or when an output byte has been taken. Each of the two interrupt sources has its own enable bit. The strobe and acknowledge lines come from outside the clock domain, so they are synchronised and edge-detected before they act. The channel also presents a status byte laid out in port-C bit positions. A parameter chooses between the layout of the wide channel and that of the narrow channel.

Top module: `hs_port_channel`

## Requirements
- R1: In output or bidirectional mode (`mode_sel` 01, 10 or 11), a `cpu_wr` latches `cpu_wdata`, puts it on `pin_out` and drives `obf_n` low on the next clock edge.
- R2: A falling edge on `ack_n`, seen after synchronisation, returns `obf_n` high. If a CPU write lands in the same cycle, the write wins and `obf_n` stays low.
- R3: In input or bidirectional mode (`mode_sel` 00, 10 or 11), a falling edge on `stb_n`, seen after synchronisation, captures `pin_in` into the input latch, sets `ibf` high and makes the byte readable on `cpu_rdata`.
- R4: `cpu_rd` clears `ibf` and the input interrupt request. If a strobe capture lands in the same cycle, the capture wins and `ibf` stays high.
- R5: The input request sets on a rising `stb_n` edge while `ibf` is high. The output request sets on a rising `ack_n` edge while `obf_n` is high. A CPU write clears the output request.
- R6: `irq` is high exactly when some request is pending and its enable bit is set. `ie_wr` loads the enable bits from `ie_wdata`: bit 0 enables the input request and bit 1 enables the output request.
- R7: `pin_oe` is 1 in output mode and 0 in input mode. In bidirectional mode it follows the `ack_n` pin directly: it is 1 while `ack_n` is low and 0 otherwise.
- R8: In input mode `cpu_wr` has no effect: `obf_n` stays high and `pin_oe` stays low. In output mode a strobe has no effect: `ibf` stays low and `cpu_rdata` keeps its value.
- R9: With `CH_A`=1, the status byte holds `obf_n` in bit 7, synchronised `ack_n` in bit 6, `ibf` in bit 5, synchronised `stb_n` in bit 4 and `irq` in bit 3, with bits 2:0 zero. With `CH_A`=0, bit 2 holds the synchronised strobe (input mode) or acknowledge, bit 1 holds `ibf` (input mode) or `obf_n`, and bit 0 holds `irq`.
- R10: Reset leaves `obf_n`=1, `ibf`=0, `irq`=0, both enables clear and both latches zero.
- R11: With `SYNC_STAGES`=2, `ibf` is still low two clock edges after `stb_n` falls and is high after the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | 00 input, 01 output, 10/11 bidirectional |
| cpu_wr | input | 1 | CPU write strobe for the output latch |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe for the input latch |
| cpu_rdata | output | 8 | Input latch contents |
| ie_wr | input | 1 | Load the interrupt enable bits |
| ie_wdata | input | 2 | Enable bits: bit 0 input, bit 1 output |
| irq | output | 1 | Interrupt request to the CPU |
| pin_in | input | 8 | Peripheral data pins, input side |
| pin_out | output | 8 | Peripheral data pins, output side |
| pin_oe | output | 1 | Tri-state enable for `pin_out` |
| stb_n | input | 1 | Active-low strobe from the peripheral |
| ack_n | input | 1 | Active-low acknowledge from the peripheral |
| obf_n | output | 1 | Active-low output buffer full |
| ibf | output | 1 | Input buffer full |
| status | output | 8 | Status byte in port-C positions |

## Verification
The assertions check the flag invariants on every cycle:
- a write empties nothing and always fills the output side;
- an acknowledge alone empties it;
- a strobe edge always fills the input side;
- a read alone empties it;
- a pending request always implies the matching buffer state;
- the interrupt is silent while both enables are clear;
- the pins float in input mode.

Only the bench scenarios can show these:
- the synchroniser latency in exact edges;
- the same-cycle races between a read or write and a handshake edge;
- the data values that come through the latches;
- the status byte layout;
- the combinational tracking of acknowledge by `pin_oe` in bidirectional mode.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

  localparam logic [1:0] HS_MODE_IN  = 2'b00;
  localparam logic [1:0] HS_MODE_OUT = 2'b01;

  // input path active in input and both bidirectional codes
  function automatic logic mode_has_in(input logic [1:0] m);
    return m != HS_MODE_OUT;
  endfunction

  // output path active in output and both bidirectional codes
  function automatic logic mode_has_out(input logic [1:0] m);
    return m != HS_MODE_IN;
  endfunction

  function automatic logic mode_is_bidir(input logic [1:0] m);
    return m[1];
  endfunction

  // interrupt: each pending request gated by its enable bit
  function automatic logic irq_combine(input logic [1:0] ie,
                                       input logic in_req,
                                       input logic out_req);
    return (ie[0] & in_req) | (ie[1] & out_req);
  endfunction

  // status byte in port-C bit positions
  function automatic logic [7:0] status_byte(input bit ch_a,
                                             input logic [1:0] m,
                                             input logic obf_n,
                                             input logic ack_lvl,
                                             input logic ibf,
                                             input logic stb_lvl,
                                             input logic irq);
    logic [7:0] s;
    s = '0;
    if (ch_a) begin
      s[7] = obf_n;
      s[6] = ack_lvl;
      s[5] = ibf;
      s[4] = stb_lvl;
      s[3] = irq;
    end else begin
      s[2] = (m == HS_MODE_IN) ? stb_lvl : ack_lvl;
      s[1] = (m == HS_MODE_IN) ? ibf : obf_n;
      s[0] = irq;
    end
    return s;
  endfunction

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= line_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

endmodule

// File: rtl/hs_in_path.sv
module hs_in_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stb_fall,
  input  logic         stb_rise,
  input  logic [W-1:0] pin_in,
  input  logic         cpu_rd,
  output logic [W-1:0] in_data,
  output logic         ibf,
  output logic         in_req
);
  logic capture;
  assign capture = en & stb_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= '0;
      ibf     <= 1'b0;
    end else if (capture) begin
      in_data <= pin_in;
      ibf     <= 1'b1;
    end else if (cpu_rd) begin
      ibf     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      in_req <= 1'b0;
    else if (cpu_rd)                 in_req <= 1'b0;
    else if (en && stb_rise && ibf)  in_req <= 1'b1;
  end

  AST_IBF_SETS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb_fall) |=> ibf); // R3
  AST_READ_EMPTIES_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !(en && stb_fall)) |=> !ibf); // R4
  AST_INREQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |-> ibf); // R5

endmodule

// File: rtl/hs_out_path.sv
module hs_out_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  input  logic         ack_fall,
  input  logic         ack_rise,
  output logic [W-1:0] out_data,
  output logic         obf_n,
  output logic         out_req
);
  logic load;
  assign load = en & cpu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      obf_n    <= 1'b1;
    end else if (load) begin
      out_data <= cpu_wdata;
      obf_n    <= 1'b0;
    end else if (en && ack_fall) begin
      obf_n    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        out_req <= 1'b0;
    else if (load)                     out_req <= 1'b0;
    else if (en && ack_rise && obf_n)  out_req <= 1'b1;
  end

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cpu_wr) |=> !obf_n); // R1
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ack_fall && !cpu_wr) |=> obf_n); // R2
  AST_OUTREQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> obf_n); // R5
  AST_NO_FILL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && obf_n) |=> obf_n); // R8

endmodule

// File: rtl/hs_port_channel.sv
module hs_port_channel
  import hs_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit CH_A        = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ie_wr,
  input  logic [1:0]        ie_wdata,
  output logic              irq,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic              pin_oe,
  input  logic              stb_n,
  input  logic              ack_n,
  output logic              obf_n,
  output logic              ibf,
  output logic [7:0]        status
);
  // synchronised handshake events, brought out as named wires
  logic stb_lvl, stb_rise, stb_fall;
  logic ack_lvl, ack_rise, ack_fall;
  logic in_en, out_en;
  logic in_req, out_req;
  logic [1:0] ie_q;

  assign in_en  = mode_has_in(mode_sel);
  assign out_en = mode_has_out(mode_sel);

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_stb (
    .clk(clk), .rst_n(rst_n), .line_n(stb_n),
    .level(stb_lvl), .rise(stb_rise), .fall(stb_fall)
  );

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_ack (
    .clk(clk), .rst_n(rst_n), .line_n(ack_n),
    .level(ack_lvl), .rise(ack_rise), .fall(ack_fall)
  );

  hs_in_path #(.W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .en(in_en),
    .stb_fall(stb_fall), .stb_rise(stb_rise),
    .pin_in(pin_in), .cpu_rd(cpu_rd),
    .in_data(cpu_rdata), .ibf(ibf), .in_req(in_req)
  );

  hs_out_path #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(out_en),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .ack_fall(ack_fall), .ack_rise(ack_rise),
    .out_data(pin_out), .obf_n(obf_n), .out_req(out_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 2'b00;
    else if (ie_wr) ie_q <= ie_wdata;
  end

  assign irq = irq_combine(ie_q, in_req, out_req);

  // pins: always driven in output mode, gated by raw acknowledge in bidirectional mode
  always_comb begin
    if (mode_is_bidir(mode_sel)) pin_oe = ~ack_n;
    else                         pin_oe = (mode_sel == HS_MODE_OUT);
  end

  assign status = status_byte(CH_A, mode_sel, obf_n, ack_lvl, ibf, stb_lvl, irq);

  AST_IRQ_SILENT_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == 2'b00) |-> !irq); // R6
  AST_INPUT_PINS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == HS_MODE_IN) |-> !pin_oe); // R7

endmodule

// File: tb/sim_hs_port_channel.sv
module sim_hs_port_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_rdata;
  logic       ie_wr = 1'b0;
  logic [1:0] ie_wdata = '0;
  logic       irq;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic       pin_oe;
  logic       stb_n = 1'b1;
  logic       ack_n = 1'b1;
  logic       obf_n;
  logic       ibf;
  logic [7:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hs_port_channel u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .irq(irq),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .stb_n(stb_n), .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; mode_sel = m; stb_n = 1'b1; ack_n = 1'b1;
    cpu_wr = 0; cpu_rd = 0; ie_wr = 0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    cpu_wdata = d; cpu_wr = 1'b1; tick(1); cpu_wr = 1'b0;
  endtask

  task automatic cpu_read();
    cpu_rd = 1'b1; tick(1); cpu_rd = 1'b0;
  endtask

  task automatic set_ie(input logic [1:0] v);
    ie_wdata = v; ie_wr = 1'b1; tick(1); ie_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'b01);
    chk("R10 obf_n", obf_n, 1);
    chk("R10 ibf", ibf, 0);
    chk("R10 irq", irq, 0);
    chk("R10 rdata", cpu_rdata, 8'h00);
    chk("R10 pin_out", pin_out, 8'h00);
    chk("R9 status idle", status, 8'hD0);
  endtask

  task automatic t_output();
    do_reset(2'b01);
    set_ie(2'b10);
    cpu_write(8'hA5);
    chk("R1 obf_n low", obf_n, 0);
    chk("R1 pin_out", pin_out, 8'hA5);
    chk("R7 oe output mode", pin_oe, 1);
    chk("R9 status filled", status, 8'h50);
    ack_n = 1'b0; tick(4);
    chk("R2 ack empties", obf_n, 1);
    chk("R5 no req before ack rise", irq, 0);
    ack_n = 1'b1; tick(4);
    chk("R5 out req on ack rise", irq, 1);
    cpu_write(8'h5A);
    chk("R5 write clears out req", irq, 0);
    chk("R1 second data", pin_out, 8'h5A);
    // same-cycle race: ack fall event lands on the write edge
    ack_n = 1'b0; tick(2);
    cpu_write(8'h77);
    chk("R2 write wins over ack", obf_n, 0);
    ack_n = 1'b1; tick(4);
  endtask

  task automatic t_input();
    do_reset(2'b00);
    set_ie(2'b01);
    pin_in = 8'h3C; stb_n = 1'b0;
    tick(2);
    chk("R11 ibf low after two edges", ibf, 0);
    tick(1);
    chk("R11 ibf high after third edge", ibf, 1);
    chk("R3 captured data", cpu_rdata, 8'h3C);
    chk("R5 no in req while strobe low", irq, 0);
    pin_in = 8'hFF; stb_n = 1'b1; tick(4);
    chk("R5 in req on strobe rise", irq, 1);
    chk("R9 status input pending", status, 8'hF8);
    chk("R3 latch held after strobe", cpu_rdata, 8'h3C);
    cpu_read();
    chk("R4 read clears ibf", ibf, 0);
    chk("R4 read clears irq", irq, 0);
    // capture and read in the same cycle
    pin_in = 8'h81; stb_n = 1'b0; tick(2);
    chk("R4 setup ibf clear", ibf, 0);
    stb_n = 1'b0; tick(0);
    cpu_read();
    chk("R4 capture wins over read", ibf, 1);
    chk("R4 race data", cpu_rdata, 8'h81);
    stb_n = 1'b1; tick(4);
  endtask

  task automatic t_enable();
    do_reset(2'b00);
    pin_in = 8'h42; stb_n = 1'b0; tick(4); stb_n = 1'b1; tick(4);
    chk("R6 pending but disabled", irq, 0);
    set_ie(2'b10);
    chk("R6 wrong enable bit", irq, 0);
    set_ie(2'b01);
    chk("R6 enabled", irq, 1);
    set_ie(2'b00);
    chk("R6 disabled again", irq, 0);
  endtask

  task automatic t_bidir();
    do_reset(2'b10);
    cpu_write(8'hC3);
    chk("R7 bidir floats with ack high", pin_oe, 0);
    ack_n = 1'b0; #1;
    chk("R7 bidir drives with ack low", pin_oe, 1);
    chk("R1 bidir data", pin_out, 8'hC3);
    tick(4);
    ack_n = 1'b1; #1;
    chk("R7 bidir floats after ack", pin_oe, 0);
    chk("R2 bidir ack empties", obf_n, 1);
    tick(1);
    pin_in = 8'h19; stb_n = 1'b0; tick(4); stb_n = 1'b1; tick(4);
    chk("R3 bidir capture", cpu_rdata, 8'h19);
    chk("R3 bidir ibf", ibf, 1);
  endtask

  task automatic t_ignored();
    do_reset(2'b00);
    cpu_write(8'hEE);
    chk("R8 write ignored obf_n", obf_n, 1);
    chk("R8 write ignored oe", pin_oe, 0);
    do_reset(2'b01);
    pin_in = 8'h99; stb_n = 1'b0; tick(4); stb_n = 1'b1; tick(4);
    chk("R8 strobe ignored ibf", ibf, 0);
    chk("R8 strobe ignored data", cpu_rdata, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_output();
    t_input();
    t_enable();
    t_bidir();
    t_ignored();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule